// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is the data path of a small general-purpose I/O port. Software reaches it through a window of word addresses on a simple register bus. The word-address bits of each access act as a per-pin mask. A write therefore changes only the selected pins, and a read shows only the selected pins. Software can set or clear one pin, or any group of pins, in a single bus access, with no read-modify-write sequence and no lock.

The block holds the output data latch. It takes a direction vector and the raw pin levels, and it drives an output value and an output enable per pin to the pads. Each raw pin level passes through a synchroniser chain before the read path can see it. When software reads a pin, an output pin returns the value held in the latch and an input pin returns the synchronised level seen at the pad.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the data latch is all zeros, so with every pin set as an output, pad_out is 0 and a full-mask read returns 0.
- R2: On a write (bus_sel=1, bus_wr=1), each latch bit whose mask bit is 1 takes the matching bit of bus_wdata. Mask bit n is byte-address bit n+2, so a full-mask write uses address 0x3FC.
- R3: On a write, each latch bit whose mask bit is 0 keeps its previous value.
- R4: On a read (bus_sel=1, bus_wr=0), every bus_rdata bit whose mask bit is 0 reads 0, and bus_rdata bits at and above PIN_W always read 0. bus_rdata is 0 whenever no read is in progress.
- R5: On a read, a masked pin whose dir_i bit is 1 (output) returns its latch bit, in the same cycle as the read (combinational read).
- R6: On a read, a masked pin whose dir_i bit is 0 (input) returns its synchronised pin level.
- R7: pad_oe equals dir_i, and pad_out is the latch ANDed with dir_i, so written data reaches a pin only when that pin is an output.
- R8: A write to byte address 1 << (n+2) changes pin n alone. This sets or clears a single pin while every other latch bit keeps its value.
- R9: The latch does not change when bus_sel is 0. Byte-address bits [1:0] play no part in the mask.
- R10: A change on pin_i becomes visible on a read after exactly SYNC_STAGES rising clock edges, and not sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the port window |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address inside the window; bits [PIN_W+1:2] form the mask |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| dir_i | input | PIN_W | Per-pin direction, 1 = output |
| pin_i | input | PIN_W | Raw pin levels from the pads |
| pad_out | output | PIN_W | Value driven toward the pads |
| pad_oe | output | PIN_W | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: eight pins, a ten-bit byte address, a 32-bit data bus and a two-stage synchroniser. With these values the bench can walk all 256 masks, both single-pin set and clear at every pin, and the exact edge on which a new pin level shows up. A behavioural model tracks the latch and a queue of past pin levels. It predicts pad_out, pad_oe and bus_rdata for every cycle, including cycles with mixed directions and with the mask bits and the direction bits in different combinations.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Mask from a byte address: word-address bits start at byte bit 2.
  function automatic logic [31:0] addr_to_mask(input logic [31:0] byte_addr,
                                               input int unsigned pins);
    logic [31:0] keep;
    keep = (32'd1 << pins) - 32'd1;
    return (byte_addr >> 2) & keep;
  endfunction

  // Replace only the bits selected by mask.
  function automatic logic [31:0] merge_masked(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Per-pin readback: outputs show the latch, inputs show the pad.
  function automatic logic [31:0] pin_view(input logic [31:0] dir_v,
                                           input logic [31:0] latch_v,
                                           input logic [31:0] pad_v);
    return (dir_v & latch_v) | (~dir_v & pad_v);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] raw_i,
  output logic [PIN_W-1:0] sync_o
);

  logic [PIN_W-1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= raw_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[SYNC_STAGES-1];

  // R10
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[0] == $past(raw_i)));

endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [PIN_W-1:0]  wmask,
  input  logic [DATA_W-1:0] wdata,
  output logic [PIN_W-1:0]  latch_q
);

  logic [31:0]      merged_w;
  logic [PIN_W-1:0] latch_d;

  always_comb begin
    merged_w = merge_masked(32'(latch_q), 32'(wdata[PIN_W-1:0]), 32'(wmask));
    latch_d  = merged_w[PIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (wr_fire) latch_q <= latch_d;
  end

  // R2
  masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((latch_q & $past(wmask)) == ($past(wdata[PIN_W-1:0]) & $past(wmask))));

  // R3
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((latch_q & ~$past(wmask)) == ($past(latch_q) & ~$past(wmask))));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(latch_q));

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [PIN_W-1:0]  rmask,
  input  logic [PIN_W-1:0]  dir_v,
  input  logic [PIN_W-1:0]  latch_v,
  input  logic [PIN_W-1:0]  pad_v,
  output logic [DATA_W-1:0] rdata
);

  logic [31:0]      view_w;
  logic [PIN_W-1:0] shown;

  always_comb begin
    view_w = pin_view(32'(dir_v), 32'(latch_v), 32'(pad_v));
    shown  = view_w[PIN_W-1:0] & rmask;
    rdata  = '0;
    if (rd_fire) rdata[PIN_W-1:0] = shown;
  end

  always_comb begin
    if (rst_n) begin
      // R4
      unmasked_zero_chk: assert ((rdata[PIN_W-1:0] & ~rmask) == '0);
      // R4
      idle_zero_chk: assert (rd_fire || (rdata == '0));
    end
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  dir_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);

  // Named events for the checks.
  logic             wr_fire;
  logic             rd_fire;
  logic [31:0]      mask_w;
  logic [PIN_W-1:0] acc_mask;
  logic [PIN_W-1:0] latch_q;
  logic [PIN_W-1:0] pad_sync;

  assign wr_fire = bus_sel &  bus_wr;
  assign rd_fire = bus_sel & ~bus_wr;

  always_comb begin
    mask_w   = addr_to_mask(32'(bus_addr), PIN_W);
    acc_mask = mask_w[PIN_W-1:0];
  end

  gpio_in_sync #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pad_sync)
  );

  gpio_data_latch #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wmask(acc_mask),
    .wdata(bus_wdata), .latch_q(latch_q)
  );

  gpio_read_mux #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_rmux (
    .rst_n(rst_n), .rd_fire(rd_fire), .rmask(acc_mask), .dir_v(dir_i),
    .latch_v(latch_q), .pad_v(pad_sync), .rdata(bus_rdata)
  );

  assign pad_oe  = dir_i;
  assign pad_out = latch_q & dir_i;

  always_comb begin
    if (rst_n && rd_fire) begin
      // R5
      out_readback_chk: assert ((bus_rdata[PIN_W-1:0] & acc_mask & dir_i) ==
                                (latch_q & acc_mask & dir_i));
      // R6
      in_readback_chk: assert ((bus_rdata[PIN_W-1:0] & acc_mask & ~dir_i) ==
                               (pad_sync & acc_mask & ~dir_i));
    end
  end

endmodule

// File: tb/gpio_masked_port_test.sv
`timescale 1ns/100ps
module gpio_masked_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  dir_i = '0;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_masked_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dir_i(dir_i), .pin_i(pin_i), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Behavioural reference: integer latch and a queue of past pin levels.
  int   ref_lat = 0;
  int   pin_hist[$];

  function automatic int mask_of(input int a);
    return (a / 4) % 256;
  endfunction

  function automatic int ref_read();
    int v = 0;
    int mk = mask_of(bus_addr);
    int pad = pin_hist[0];
    if (!(bus_sel && !bus_wr)) return 0;
    for (int b = 0; b < 8; b++)
      if (mk[b]) v[b] = dir_i[b] ? ref_lat[b] : pad[b];
    return v;
  endfunction

  initial begin
    pin_hist.push_back(0);
    pin_hist.push_back(0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lat <= 0;
      pin_hist = {0, 0};
    end else begin
      if (bus_sel && bus_wr)
        for (int b = 0; b < 8; b++)
          if (mask_of(bus_addr) & (1 << b)) ref_lat[b] <= bus_wdata[b];
      pin_hist.push_back(int'(pin_i));
      void'(pin_hist.pop_front());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R7 pad_oe", int'(pad_oe), int'(dir_i));
      check("R7 pad_out", int'(pad_out), ref_lat & int'(dir_i));
      check("R4 model rdata", int'(bus_rdata), ref_read());
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 10'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, input string tag, input int exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 10'(a);
    #1;
    check(tag, int'(bus_rdata), exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    dir_i = 8'hFF;
    #1;
    check("R1 pad_out after reset", int'(pad_out), 0);
    rd(10'h3FC, "R1 read after reset", 0);

    wr(10'h3FC, 32'hFFFF_FFA5);
    rd(10'h3FC, "R2 full write", 8'hA5);
    wr(10'h03C, 32'h0000_003C);
    rd(10'h3FC, "R3 upper nibble kept", 8'hAC);
    rd(10'h3C0, "R4 masked read upper", 8'hA0);
    rd(10'h03C, "R4 masked read lower", 8'h0C);

    wr(10'h008, 32'h02);
    rd(10'h3FC, "R8 single set pin1", 8'hAE);
    wr(10'h200, 32'h00);
    rd(10'h3FC, "R8 single clear pin7", 8'h2E);

    @(negedge clk);
    bus_sel = 0; bus_wr = 1; bus_addr = 10'h3FC; bus_wdata = 32'hFF;
    @(negedge clk);
    bus_wr = 0;
    rd(10'h3FC, "R9 no write without select", 8'h2E);
    wr(10'h3FF, 32'h00);
    rd(10'h3FC, "R9 low address bits ignored", 8'h00);
    wr(10'h3FC, 32'h2E);

    @(negedge clk);
    dir_i = 8'h0F; pin_i = 8'h50;
    repeat (3) @(negedge clk);
    #1;
    check("R7 pad_out masked by dir", int'(pad_out), 8'h0E);
    rd(10'h3FC, "R5 R6 mixed readback", 8'h5E);

    @(negedge clk);
    pin_i = 8'hF0;
    bus_sel = 1; bus_wr = 0; bus_addr = 10'h3C0;
    @(negedge clk); #1;
    check("R10 one edge not yet", int'(bus_rdata), 8'h50);
    @(negedge clk); #1;
    check("R10 visible after two edges", int'(bus_rdata), 8'hF0);
    bus_sel = 0;

    for (int m = 0; m < 256; m++) begin
      @(negedge clk);
      dir_i = 8'($urandom);
      pin_i = 8'($urandom);
      bus_sel = 1; bus_wr = m[0]; bus_addr = 10'((m << 2) | (m % 4));
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_sel = 0;
    for (int n = 0; n < 8; n++) begin
      dir_i = 8'hFF;
      wr(1 << (n + 2), 32'hFF);
      check("R8 set pin", (int'(pad_out) >> n) & 1, 1);
      wr(1 << (n + 2), 32'h00);
      check("R8 clear pin", (int'(pad_out) >> n) & 1, 0);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule